// File: doc/BRIEF.md
# Block Graphics Dot Serializer

This block turns one character cell into the serial dot stream for the scan row being drawn. Once per cell it takes a character code, the scan row inside the 12-row cell, a five-dot font slice and a width mode. It then sends the cell out one dot per clock, six dots wide, leftmost dot first.

A code with its top bit set is drawn as block graphics. The cell is split into a grid two rectangles wide and three tall, and each of the six low code bits lights one rectangle. Any other code is drawn as text from the font slice. In text mode the sixth dot of each row is always dark, which leaves a gap between characters.

In double-width mode every dot lasts two clocks. Any of several inhibit inputs, such as the blanking intervals, forces the output dark at once. The fetch logic around the block watches a take strobe and places the next cell's inputs on the pins while that strobe is high.

Top module: `block_dot_serializer`

## Requirements
- R1: While reset is asserted and right after it, `dot` is 0 and `cell_take` is 1.
- R2: `cell_take` is high for one clock in every 6 in normal width and in every 12 in double width. The inputs are captured on the rising edge that ends a `cell_take` cycle.
- R3: The first dot of a captured cell appears in the cycle after the capture edge. The six dots follow from left to right, and the rightmost dot shows during the next `cell_take` cycle.
- R4: `cell_code[7]` = 1 selects graphics decoding and 0 selects text. `cell_code[6]` has no effect in either mode.
- R5: In graphics mode, scan rows 0 to 3 use code bits 0 and 1, rows 4 to 7 use bits 2 and 3, and rows 8 to 11 use bits 4 and 5. The even bit sets the left three dots and the odd bit sets the right three dots.
- R6: In text mode, `font_row[5]` down to `font_row[1]` give dots 1 to 5 from the left. The sixth dot is always 0, and `font_row[0]` is ignored.
- R7: `font_row` has no effect in graphics mode. `cell_code[5:0]` has no effect in text mode.
- R8: With `wide` = 1 each dot is held for two consecutive clocks.
- R9: If any bit of `inhibit` is 1, `dot` is 0 in that same cycle. Shifting continues underneath, so later dots are not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_code | input | 8 | Character code; bit 7 selects graphics |
| scan_row | input | 4 | Scan row within the cell, 0 to 11 |
| font_row | input | 6 | Text font slice, bit 5 leftmost, bit 0 unused |
| wide | input | 1 | Double-width dot mode |
| inhibit | input | INHIBITS | Blanking inputs; any bit set darkens the output |
| cell_take | output | 1 | High in the cycle whose closing edge captures a cell |
| dot | output | 1 | Serial dot output |

## Verification
A cell captured at the edge that closes a `cell_take` cycle shows its first dot one cycle later. Each of the following dots arrives one cycle later in normal width, or two cycles later in double width. The sixth dot therefore lands in the next `cell_take` cycle.

The driver applies inputs just after a falling edge and queues the per-clock dot values it expects. The monitor removes one expected value at every falling edge, half a cycle away from the register update. The inhibit inputs act within the same cycle, so the expected value for an inhibited cell is 0 on every one of its clocks. The spacing between take strobes is also counted, against 6 or 12 clocks.

// File: rtl/block_dot_serializer.sv
module block_dot_serializer #(
  parameter int INHIBITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          cell_code,
  input  logic [3:0]          scan_row,
  input  logic [5:0]          font_row,
  input  logic                wide,
  input  logic [INHIBITS-1:0] inhibit,
  output logic                cell_take,
  output logic                dot
);
  localparam int DOTS = 6;
  localparam int BAND_ROWS = 4;
  localparam logic [3:0] LAST_NARROW = 4'(DOTS - 1);
  localparam logic [3:0] LAST_WIDE = 4'(2 * DOTS - 1);

  logic [3:0]      cnt;
  logic [DOTS-1:0] sreg;
  logic [DOTS-1:0] gfx_pat, txt_pat, pat;
  logic [1:0]      band;
  logic [1:0]      pair;
  logic [3:0]      last;
  logic            shift_en;

  assign last      = wide ? LAST_WIDE : LAST_NARROW;
  assign cell_take = (cnt == 4'd0);
  assign shift_en  = !cell_take && (!wide || !cnt[0]);

  assign band    = (scan_row < 4'(BAND_ROWS)) ? 2'd0 :
                   (scan_row < 4'(2 * BAND_ROWS)) ? 2'd1 : 2'd2;
  assign pair    = cell_code[{band, 1'b0} +: 2];
  assign gfx_pat = {{3{pair[0]}}, {3{pair[1]}}};
  assign txt_pat = {font_row[5:1], 1'b0};
  assign pat     = cell_code[7] ? gfx_pat : txt_pat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= 4'd0;
      sreg <= '0;
    end else begin
      cnt <= (cnt >= last) ? 4'd0 : cnt + 4'd1;
      if (cell_take)
        sreg <= pat;
      else if (shift_en)
        sreg <= {sreg[DOTS-2:0], 1'b0};
    end
  end

  assign dot = sreg[DOTS-1] & ~(|inhibit);
endmodule

module block_dot_serializer_chk #(
  parameter int INHIBITS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          cell_code,
  input logic                wide,
  input logic [INHIBITS-1:0] inhibit,
  input logic                cell_take,
  input logic                dot
);
  logic shown_text;

  always_ff @(posedge clk) begin
    if (!rst_n)
      shown_text <= 1'b0;
    else if (cell_take)
      shown_text <= !cell_code[7];
  end

  p_inhibit_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|inhibit) |-> !dot);

  p_take_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cell_take |=> !cell_take);

  p_text_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_take && shown_text) |-> !dot);

  p_wide_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && cell_take) ##2 (wide && !(|inhibit) && !$past(|inhibit)) |-> $stable(dot));
endmodule

bind block_dot_serializer block_dot_serializer_chk #(.INHIBITS(INHIBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cell_code(cell_code), .wide(wide),
  .inhibit(inhibit), .cell_take(cell_take), .dot(dot)
);

// File: tb/block_dot_serializer_tb.sv
module block_dot_serializer_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] cell_code = 0;
  logic [3:0] scan_row = 0;
  logic [5:0] font_row = 0;
  logic       wide = 0;
  logic [1:0] inhibit = 0;
  logic       cell_take, dot;

  int checks = 0;
  int errors = 0;
  bit have_prev = 0;
  bit prev_wide = 0;

  typedef struct { bit val; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  block_dot_serializer #(.INHIBITS(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cell_code(cell_code), .scan_row(scan_row),
    .font_row(font_row), .wide(wide), .inhibit(inhibit),
    .cell_take(cell_take), .dot(dot)
  );

  function automatic logic [5:0] expect_pat(logic [7:0] c, logic [3:0] r, logic [5:0] f);
    int b;
    logic l, rt;
    if (!c[7]) return {f[5:1], 1'b0};
    b = (r < 4) ? 0 : (r < 8) ? 1 : 2;
    l = c[2*b];
    rt = c[2*b+1];
    return {l, l, l, rt, rt, rt};
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic drive_cell(input logic [7:0] c, input logic [3:0] r, input logic [5:0] f,
                            input bit w, input logic [1:0] inh, input string tag);
    int n = 0;
    logic [5:0] p;
    exp_t e;
    do begin
      @(negedge clk);
      n++;
    end while (!cell_take);
    if (have_prev) begin
      checks++;
      if (n != (prev_wide ? 12 : 6)) begin
        errors++;
        $display("FAIL R2 take spacing actual=%0d expected=%0d", n, prev_wide ? 12 : 6);
      end
    end
    #1;
    cell_code = c; scan_row = r; font_row = f; wide = w; inhibit = inh;
    p = expect_pat(c, r, f);
    for (int i = 5; i >= 0; i--) begin
      for (int k = 0; k < (w ? 2 : 1); k++) begin
        e.val = (inh != 0) ? 1'b0 : p[i];
        e.tag = tag;
        q.push_back(e);
      end
    end
    prev_wide = w;
    have_prev = 1;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (dot !== e.val) begin
          errors++;
          $display("FAIL %s dot actual=%0b expected=%0b", e.tag, dot, e.val);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (dot !== 1'b0 || cell_take !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset dot=%0b take=%0b expected dot=0 take=1", dot, cell_take);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (dot !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset dot actual=%0b expected=0", dot);
    end

    // R3 / R6: text order and forced gap
    drive_cell(8'h00, 4'd0, 6'b101011, 0, 2'b00, "R6");
    drive_cell(8'h00, 4'd5, 6'b111111, 0, 2'b00, "R6");
    drive_cell(8'h00, 4'd2, 6'b000001, 0, 2'b00, "R6");
    drive_cell(8'h00, 4'd1, 6'b100000, 0, 2'b00, "R3");
    // R7: code bits ignored in text
    drive_cell(8'h3F, 4'd0, 6'b000000, 0, 2'b00, "R7");
    // R5: band mapping
    drive_cell(8'h81, 4'd0, 6'b000000, 0, 2'b00, "R5");
    drive_cell(8'h81, 4'd3, 6'b000000, 0, 2'b00, "R5");
    drive_cell(8'h82, 4'd2, 6'b000000, 0, 2'b00, "R5");
    drive_cell(8'h84, 4'd4, 6'b000000, 0, 2'b00, "R5");
    drive_cell(8'h88, 4'd7, 6'b000000, 0, 2'b00, "R5");
    drive_cell(8'h90, 4'd8, 6'b000000, 0, 2'b00, "R5");
    drive_cell(8'hA0, 4'd11, 6'b000000, 0, 2'b00, "R5");
    drive_cell(8'h8C, 4'd0, 6'b000000, 0, 2'b00, "R5");
    drive_cell(8'hBF, 4'd6, 6'b000000, 0, 2'b00, "R5");
    // R7: font ignored in graphics
    drive_cell(8'h80, 4'd0, 6'b111111, 0, 2'b00, "R7");
    // R4: bit 7 selects, bit 6 ignored
    drive_cell(8'hC0, 4'd0, 6'b111111, 0, 2'b00, "R4");
    drive_cell(8'h43, 4'd0, 6'b000000, 0, 2'b00, "R4");
    drive_cell(8'hC3, 4'd9, 6'b000000, 0, 2'b00, "R4");
    // R8: double width
    drive_cell(8'h00, 4'd0, 6'b101010, 1, 2'b00, "R8");
    drive_cell(8'h81, 4'd1, 6'b000000, 1, 2'b00, "R8");
    drive_cell(8'h00, 4'd3, 6'b011111, 0, 2'b00, "R8");
    // R9: inhibit inputs
    drive_cell(8'hBF, 4'd5, 6'b000000, 0, 2'b01, "R9");
    drive_cell(8'h00, 4'd5, 6'b111111, 0, 2'b10, "R9");
    drive_cell(8'hBF, 4'd5, 6'b000000, 1, 2'b11, "R9");
    drive_cell(8'hA5, 4'd10, 6'b000000, 0, 2'b00, "R9");
    drive_cell(8'h00, 4'd0, 6'b000000, 0, 2'b00, "R3");

    repeat (14) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R3 leftover expected dots actual=%0d expected=0", q.size());
    end
    summary();
    $finish;
  end
endmodule